// File: doc/BRIEF.md
# Program-Memory Data Window Bridge

This block lets a 16-bit data read reach constant data held in a 24-bit-wide program memory without special instructions. Each data read comes with its effective address and a window-enable bit. When the address lies in the upper half of data space and the window is open, the read goes to program memory instead of data RAM. The program address is formed from an 8-bit page register and the low address bits. Only the low 16 bits of the fetched word come back. A byte read or a double-word read is shaped as the core expects.

The block also tells the core how many extra cycles the access costs, and holds a stall output high for exactly that many cycles. The count depends on the kind of instruction and on where the access falls inside a hardware repeat loop. The core supplies these context flags with each read. While a table read or table write is in progress, the window is closed.

Top module: `pgm_window_bridge`

## Requirements
- R1: A read (`rd_req`=1) is sent to program memory (`pm_req`=1 in the same cycle, `ram_req`=0) only when `rd_ea[15]`=1 and `win_en`=1 and `tbl_busy`=0. Every other read raises `ram_req` in the same cycle and issues no program-memory request.
- R2: While `tbl_busy`=1, a read with `rd_ea[15]`=1 and `win_en`=1 goes to data RAM. No program fetch, no data return and no stall follow from it.
- R3: The program address is `{1'b0, page[7:0], rd_ea[14:1], 1'b0}`. Bit 23 is zero, bits 22:15 hold the page and bits 14:1 hold the address bits unchanged. The word address is always even.
- R4: A word read returns bits 15:0 of the fetched 24-bit program word on `rd_data`. Bits 23:16 of the word have no effect on the result.
- R5: For a byte read (`rd_byte`=1) that is not a double move, `rd_ea[0]`=0 returns bits 7:0 of the word and `rd_ea[0]`=1 returns bits 15:8. The selected byte is placed in `rd_data[7:0]` and `rd_data[15:8]` is zero.
- R6: A double move (`is_double_move`=1) fetches the formed address in the request cycle and the formed address plus 2 in the next cycle. Two cycles after the request, `rd_valid` is 1 for one cycle, with the first word on `rd_data` and the second word on `rd_data2`.
- R7: A single-word or byte read raises `rd_valid` for exactly one cycle, the cycle after the request. Window reads on consecutive cycles each return their own data.
- R8: Outside a repeat loop (`in_repeat`=0), a window read raises `stall` starting in the cycle after the request. The stall lasts 1 contiguous cycle for a double move and 2 contiguous cycles otherwise.
- R9: Inside a repeat loop (`in_repeat`=1), a window read stalls for 2 cycles when any of `repeat_first`, `repeat_last`, `irq_exit` or `irq_reenter` is 1. Otherwise it causes no stall.
- R10: The page register is loaded from `page_wdata` when `page_we`=1 and takes effect from the next cycle. A page write in the same cycle as a double-move request changes neither of that access's two addresses, but it applies to later accesses.
- R11: After reset, the page register is 0 and `stall`, `rd_valid` and `pm_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_we | input | 1 | Write strobe for the page register |
| page_wdata | input | 8 | New page value |
| rd_req | input | 1 | Data read request, one cycle per read |
| rd_ea | input | 16 | Effective address of the read |
| rd_byte | input | 1 | Byte-sized read |
| win_en | input | 1 | Window enable control bit |
| tbl_busy | input | 1 | Table read/write in progress; closes the window |
| is_double_move | input | 1 | Read belongs to a double-word move |
| in_repeat | input | 1 | Read executes inside a hardware repeat loop |
| repeat_first | input | 1 | First iteration of the loop |
| repeat_last | input | 1 | Last iteration of the loop |
| irq_exit | input | 1 | Iteration left because of an interrupt |
| irq_reenter | input | 1 | Iteration that resumes the loop after an interrupt |
| ram_req | output | 1 | Read routed to ordinary data RAM |
| pm_req | output | 1 | Program-memory read request |
| pm_addr | output | 24 | Program-memory byte address |
| pm_rvalid | input | 1 | Program-memory data valid, one cycle after `pm_req` |
| pm_rdata | input | 24 | Program-memory read word |
| rd_valid | output | 1 | Returned window data valid |
| rd_data | output | 16 | Returned word or byte (first word of a double move) |
| rd_data2 | output | 16 | Second word of a double move |
| stall | output | 1 | Core stall for the access penalty |

## Verification
The bench builds the block with its default widths: a 16-bit effective address, an 8-bit page and a 24-bit program word and address. With these widths, the whole page range from 0x00 to 0xFF and the edges of the window at 0x7FFE, 0x8000 and 0xFFFE can all be driven directly. The program-memory model puts an address-dependent pattern into both halves of each word. A wrong page or offset bit therefore shows up in the returned data, and any leak of the upper byte would show up as well. Every stall case is reached, in both repeat and non-repeat contexts. A page write in the same cycle as a double move and back-to-back repeat reads with no stall are also covered.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    // Penalty classes for one window access
    typedef enum logic [1:0] {
        PEN_NONE = 2'd0,
        PEN_ONE  = 2'd1,
        PEN_TWO  = 2'd2
    } pgw_pen_e;

    // Context that travels with a read from the core
    typedef struct packed {
        logic dbl;
        logic in_rep;
        logic rep_first;
        logic rep_last;
        logic irq_out;
        logic irq_back;
    } pgw_ctx_t;

    function automatic logic rep_edge(input pgw_ctx_t c);
        return c.rep_first | c.rep_last | c.irq_out | c.irq_back;
    endfunction
endpackage

// File: rtl/pgw_addr_map.sv
module pgw_addr_map #(
    parameter int EA_W   = 16,
    parameter int PAGE_W = 8,
    parameter int PMA_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_wdata,
    input  logic              rd_req,
    input  logic [EA_W-1:0]   rd_ea,
    input  logic              win_en,
    input  logic              tbl_busy,
    output logic              hit,
    output logic              ram_req,
    output logic [PMA_W-1:0]  word_addr
);
    localparam int OFF_W = EA_W - 1;
    localparam int MAP_W = PAGE_W + OFF_W;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } map_st_t;

    map_st_t st_d, st_q;
    logic [MAP_W-1:0] mapped;

    always_comb begin
        st_d = st_q;
        if (page_we) st_d.page = page_wdata;
        hit     = rd_req & rd_ea[EA_W-1] & win_en & ~tbl_busy;
        ram_req = rd_req & ~hit;
        mapped  = {st_q.page, rd_ea[OFF_W-1:1], 1'b0};
    end

    generate
        if (PMA_W > MAP_W) begin : g_pad
            assign word_addr = {{(PMA_W-MAP_W){1'b0}}, mapped};
        end else begin : g_exact
            assign word_addr = mapped[PMA_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: every formed address is even
    a_r3_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (word_addr[0] == 1'b0));
    // R10: page register follows a write on the next cycle
    a_r10_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        page_we |=> (st_q.page == $past(page_wdata)));
endmodule

// File: rtl/pgw_stall_ctl.sv
module pgw_stall_ctl
    import pgw_pkg::*;
#(
    parameter int PEN_FULL = 2,
    parameter int PEN_DBL  = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  pgw_ctx_t ctx,
    output logic     stall
);
    localparam int PEN_MAX = (PEN_FULL > PEN_DBL) ? PEN_FULL : PEN_DBL;
    localparam int CNT_W   = $clog2(PEN_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } stall_st_t;

    stall_st_t        st_d, st_q;
    logic [CNT_W-1:0] pen;

    always_comb begin
        pen = '0;
        if (!ctx.in_rep)        pen = ctx.dbl ? CNT_W'(PEN_DBL) : CNT_W'(PEN_FULL);
        else if (rep_edge(ctx)) pen = CNT_W'(PEN_FULL);

        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (load)           st_d.cnt = pen;
        stall = (st_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a running penalty counts down by one per cycle, without gaps
    a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0 && !load) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    // R9: a middle repeat iteration brings no stall
    a_r9_quiet_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ctx.in_rep && !rep_edge(ctx) && st_q.cnt == '0) |=> !stall);
endmodule

// File: rtl/pgw_fetch_seq.sv
module pgw_fetch_seq #(
    parameter int PMA_W = 24,
    parameter int PMW_W = 24,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             is_dbl,
    input  logic             byte_rd,
    input  logic             bsel,
    input  logic [PMA_W-1:0] word_addr,
    output logic             pm_req,
    output logic [PMA_W-1:0] pm_addr,
    input  logic             pm_rvalid,
    input  logic [PMW_W-1:0] pm_rdata,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    rd_data2
);
    localparam int BW = DW / 2;

    typedef struct packed {
        logic             wait1;
        logic             wait2;
        logic             dbl;
        logic             byte_rd;
        logic             bsel;
        logic [PMA_W-1:0] addr2;
        logic [DW-1:0]    word0;
    } fetch_st_t;

    fetch_st_t     st_d, st_q;
    logic          issue2;
    logic [DW-1:0] low;

    always_comb begin
        st_d       = st_q;
        st_d.wait1 = 1'b0;
        st_d.wait2 = 1'b0;
        issue2     = st_q.wait1 & st_q.dbl;
        pm_req     = hit | issue2;
        pm_addr    = issue2 ? st_q.addr2 : word_addr;
        low        = pm_rdata[DW-1:0];

        if (hit && !issue2) begin
            st_d.wait1   = 1'b1;
            st_d.dbl     = is_dbl;
            st_d.byte_rd = byte_rd & ~is_dbl;
            st_d.bsel    = bsel;
            st_d.addr2   = word_addr + PMA_W'(2);
        end
        if (issue2) st_d.wait2 = 1'b1;

        rd_valid = 1'b0;
        rd_data  = '0;
        rd_data2 = '0;
        if (st_q.wait1 && pm_rvalid) begin
            if (st_q.dbl) begin
                st_d.word0 = low;
            end else begin
                rd_valid = 1'b1;
                if (st_q.byte_rd)
                    rd_data = {{(DW-BW){1'b0}}, st_q.bsel ? low[DW-1:BW] : low[BW-1:0]};
                else
                    rd_data = low;
            end
        end
        if (st_q.wait2 && pm_rvalid) begin
            rd_valid = 1'b1;
            rd_data  = st_q.word0;
            rd_data2 = low;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the second word of a double move sits two bytes above the first
    a_r6_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
        issue2 |-> (pm_addr == $past(pm_addr) + PMA_W'(2)));
    // R6: no new window read may collide with the second fetch slot
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        issue2 |-> !hit);
    // R7: memory answers every outstanding request one cycle later
    a_r7_resp_due: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wait1 || st_q.wait2) |-> pm_rvalid);
endmodule

// File: rtl/pgm_window_bridge.sv
module pgm_window_bridge
    import pgw_pkg::*;
#(
    parameter int EA_W     = 16,
    parameter int PAGE_W   = 8,
    parameter int PMA_W    = 24,
    parameter int PMW_W    = 24,
    parameter int DW       = 16,
    parameter int PEN_FULL = 2,
    parameter int PEN_DBL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_wdata,
    input  logic              rd_req,
    input  logic [EA_W-1:0]   rd_ea,
    input  logic              rd_byte,
    input  logic              win_en,
    input  logic              tbl_busy,
    input  logic              is_double_move,
    input  logic              in_repeat,
    input  logic              repeat_first,
    input  logic              repeat_last,
    input  logic              irq_exit,
    input  logic              irq_reenter,
    output logic              ram_req,
    output logic              pm_req,
    output logic [PMA_W-1:0]  pm_addr,
    input  logic              pm_rvalid,
    input  logic [PMW_W-1:0]  pm_rdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     rd_data2,
    output logic              stall
);
    logic             hit;
    logic [PMA_W-1:0] word_addr;
    pgw_ctx_t         ctx;

    always_comb begin
        ctx.dbl       = is_double_move;
        ctx.in_rep    = in_repeat;
        ctx.rep_first = repeat_first;
        ctx.rep_last  = repeat_last;
        ctx.irq_out   = irq_exit;
        ctx.irq_back  = irq_reenter;
    end

    pgw_addr_map #(.EA_W(EA_W), .PAGE_W(PAGE_W), .PMA_W(PMA_W)) u_map (
        .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_wdata(page_wdata),
        .rd_req(rd_req), .rd_ea(rd_ea), .win_en(win_en), .tbl_busy(tbl_busy),
        .hit(hit), .ram_req(ram_req), .word_addr(word_addr)
    );

    pgw_stall_ctl #(.PEN_FULL(PEN_FULL), .PEN_DBL(PEN_DBL)) u_stall (
        .clk(clk), .rst_n(rst_n), .load(hit), .ctx(ctx), .stall(stall)
    );

    pgw_fetch_seq #(.PMA_W(PMA_W), .PMW_W(PMW_W), .DW(DW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .hit(hit), .is_dbl(is_double_move),
        .byte_rd(rd_byte), .bsel(rd_ea[0]), .word_addr(word_addr),
        .pm_req(pm_req), .pm_addr(pm_addr), .pm_rvalid(pm_rvalid),
        .pm_rdata(pm_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_data2(rd_data2)
    );

    // R1: a read never goes to both RAM and the window
    a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_req && hit));
    // R2: a busy table unit keeps every read on the RAM side
    a_r2_table_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && tbl_busy) |-> ram_req);
    // R11: no data returns in the first cycle out of reset
    a_r11_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_valid && !stall));
endmodule

// File: tb/pgm_window_bridge_tb.sv
module pgm_window_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_ea = '0;
    logic        rd_byte = 1'b0, win_en = 1'b0, tbl_busy = 1'b0;
    logic        is_double_move = 1'b0, in_repeat = 1'b0;
    logic        repeat_first = 1'b0, repeat_last = 1'b0;
    logic        irq_exit = 1'b0, irq_reenter = 1'b0;
    logic        ram_req, pm_req, pm_rvalid, rd_valid, stall;
    logic [23:0] pm_addr, pm_rdata;
    logic [15:0] rd_data, rd_data2;
    int          checks = 0, failures = 0;

    always #4 clk = ~clk;

    pgm_window_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_wdata(page_wdata),
        .rd_req(rd_req), .rd_ea(rd_ea), .rd_byte(rd_byte), .win_en(win_en),
        .tbl_busy(tbl_busy), .is_double_move(is_double_move), .in_repeat(in_repeat),
        .repeat_first(repeat_first), .repeat_last(repeat_last), .irq_exit(irq_exit),
        .irq_reenter(irq_reenter), .ram_req(ram_req), .pm_req(pm_req),
        .pm_addr(pm_addr), .pm_rvalid(pm_rvalid), .pm_rdata(pm_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_data2(rd_data2), .stall(stall)
    );

    // Program memory model: upper byte is junk, low half depends on page and offset
    function automatic logic [23:0] pm_word(input logic [23:0] a);
        return {8'hFF ^ a[7:0], a[15:0] ^ {a[22:15], a[22:15]} ^ 16'hC3A5};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_rvalid <= 1'b0;
            pm_rdata  <= '0;
        end else begin
            pm_rvalid <= pm_req;
            pm_rdata  <= pm_req ? pm_word(pm_addr) : 24'h5A5A5A;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] form_addr(input logic [7:0] pg, input logic [15:0] ea);
        return {1'b0, pg, ea[14:1], 1'b0};
    endfunction

    // Vector: ea[34:19] page[18:11] win tbl byte dbl rep first last exit reent [10:2] stall[1:0]
    localparam logic [34:0] VEC [0:13] = '{
        {16'h8000, 8'h03, 9'b1_0_0_0_0_0_0_0_0, 2'd2},
        {16'h8004, 8'h03, 9'b1_0_0_1_0_0_0_0_0, 2'd1},
        {16'hFFFE, 8'hFF, 9'b1_0_0_0_0_0_0_0_0, 2'd2},
        {16'h8123, 8'h10, 9'b1_0_1_0_0_0_0_0_0, 2'd2},
        {16'hA462, 8'h5C, 9'b1_0_1_0_0_0_0_0_0, 2'd2},
        {16'h8000, 8'h03, 9'b0_0_0_0_0_0_0_0_0, 2'd0},
        {16'h9000, 8'h03, 9'b1_1_0_0_0_0_0_0_0, 2'd0},
        {16'h7FFE, 8'h03, 9'b1_0_0_0_0_0_0_0_0, 2'd0},
        {16'h8100, 8'h81, 9'b1_0_0_0_1_0_0_0_0, 2'd0},
        {16'h8102, 8'h81, 9'b1_0_0_0_1_1_0_0_0, 2'd2},
        {16'h8104, 8'h81, 9'b1_0_0_0_1_0_1_0_0, 2'd2},
        {16'h8106, 8'h81, 9'b1_0_0_0_1_0_0_1_0, 2'd2},
        {16'h8108, 8'h81, 9'b1_0_0_0_1_0_0_0_1, 2'd2},
        {16'hC00A, 8'h42, 9'b1_0_0_1_1_0_0_0_0, 2'd0}
    };

    task automatic set_page(input logic [7:0] pg);
        @(negedge clk);
        page_we = 1'b1; page_wdata = pg;
        @(negedge clk);
        page_we = 1'b0;
    endtask

    task automatic clear_req();
        rd_req = 0; rd_byte = 0; is_double_move = 0; in_repeat = 0;
        repeat_first = 0; repeat_last = 0; irq_exit = 0; irq_reenter = 0;
    endtask

    task automatic run_vec(input logic [34:0] v);
        logic [15:0] ea;
        logic [7:0]  pg;
        logic        hit, dbl, byt, rep;
        logic [23:0] a0;
        logic [15:0] w0, w1, exp_data;
        int          stall_n, valid_n, valid_at;
        logic [15:0] got_d, got_d2;
        string       rtag, stag, dtag;
        ea = v[34:19]; pg = v[18:11];
        dbl = v[7]; byt = v[8]; rep = v[6];
        hit = ea[15] & v[10] & ~v[9];
        rtag = v[9] ? "R2 route" : "R1 route";
        stag = rep ? "R9 stall" : "R8 stall";
        dtag = dbl ? "R6 data" : (byt ? "R5 data" : "R4 data");
        a0 = form_addr(pg, ea);
        w0 = pm_word(a0)[15:0];
        w1 = pm_word(a0 + 24'd2)[15:0];
        if (byt) exp_data = {8'h00, ea[0] ? w0[15:8] : w0[7:0]};
        else     exp_data = w0;
        set_page(pg);
        rd_req = 1; rd_ea = ea; win_en = v[10]; tbl_busy = v[9]; rd_byte = byt;
        is_double_move = dbl; in_repeat = rep; repeat_first = v[5];
        repeat_last = v[4]; irq_exit = v[3]; irq_reenter = v[2];
        #1;
        chk(rtag, {31'd0, ram_req}, {31'd0, ~hit});
        chk(rtag, {31'd0, pm_req}, {31'd0, hit});
        if (hit) chk("R3 addr", {8'd0, pm_addr}, {8'd0, a0});
        stall_n = 0; valid_n = 0; valid_at = 0; got_d = '0; got_d2 = '0;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            if (c == 1) begin
                if (hit && dbl) chk("R6 addr2", {8'd0, pm_addr}, {8'd0, a0 + 24'd2});
                clear_req();
                win_en = 0; tbl_busy = 0;
            end
            if (stall) stall_n++;
            if (rd_valid) begin
                valid_n++; valid_at = c; got_d = rd_data; got_d2 = rd_data2;
            end
        end
        chk(stag, stall_n, {30'd0, v[1:0]});
        chk(dbl ? "R6 valid" : "R7 valid", valid_n, hit ? 1 : 0);
        if (hit) begin
            chk(dbl ? "R6 when" : "R7 when", valid_at, dbl ? 2 : 1);
            chk(dtag, {16'd0, got_d}, {16'd0, exp_data});
            if (dbl) chk("R6 data2", {16'd0, got_d2}, {16'd0, w1});
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] a;
        // R11: reset state
        #2;
        chk("R11 stall", {31'd0, stall}, 32'd0);
        chk("R11 valid", {31'd0, rd_valid}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 pm_req", {31'd0, pm_req}, 32'd0);
        chk("R11 stall out", {31'd0, stall}, 32'd0);
        // R11: page starts at zero
        rd_req = 1; rd_ea = 16'h8010; win_en = 1;
        #1;
        chk("R11 page", {8'd0, pm_addr}, {8'd0, form_addr(8'h00, 16'h8010)});
        @(negedge clk);
        clear_req(); win_en = 0;
        repeat (3) @(negedge clk);

        // Table-driven walk over routing, data shaping and stall cases
        foreach (VEC[i]) run_vec(VEC[i]);

        // R10: page write in the same cycle as a double move
        set_page(8'h22);
        page_we = 1; page_wdata = 8'h77;
        rd_req = 1; rd_ea = 16'h8200; win_en = 1; is_double_move = 1;
        a = form_addr(8'h22, 16'h8200);
        #1;
        chk("R10 first addr", {8'd0, pm_addr}, {8'd0, a});
        @(negedge clk);
        page_we = 0; clear_req();
        chk("R10 second addr", {8'd0, pm_addr}, {8'd0, a + 24'd2});
        @(negedge clk);
        chk("R10 data", {rd_data, rd_data2}, {pm_word(a)[15:0], pm_word(a + 24'd2)[15:0]});
        repeat (2) @(negedge clk);
        rd_req = 1; rd_ea = 16'h8200;
        #1;
        chk("R10 new page", {8'd0, pm_addr}, {8'd0, form_addr(8'h77, 16'h8200)});
        @(negedge clk);
        clear_req();
        repeat (3) @(negedge clk);

        // R7 / R9: back-to-back middle repeat iterations, one result per cycle
        in_repeat = 1; rd_req = 1; rd_ea = 16'h8300;
        @(negedge clk);
        rd_ea = 16'h8302;
        chk("R9 no stall", {31'd0, stall}, 32'd0);
        chk("R7 b2b 0", {15'd0, rd_valid, rd_data}, {15'd0, 1'b1, pm_word(form_addr(8'h77, 16'h8300))[15:0]});
        @(negedge clk);
        clear_req(); win_en = 0;
        chk("R9 no stall b", {31'd0, stall}, 32'd0);
        chk("R7 b2b 1", {15'd0, rd_valid, rd_data}, {15'd0, 1'b1, pm_word(form_addr(8'h77, 16'h8302))[15:0]});
        @(negedge clk);
        chk("R7 single pulse", {31'd0, rd_valid}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule